// File: doc/BRIEF.md
# Short-Cycle SAR Conversion Sequencer

This block is the digital sequencer of a successive-approximation converter. A positive pulse on the convert-start input arms it, and the conversion begins when that pulse ends. A status output stays high for the whole conversion. The block works through the result one bit per bit period, starting at the MSB. Its result register is negative-true and drives both the external feedback DAC and the data outputs. At the end of each bit period a single comparator input is sampled, and the bit under test is kept or rejected.

A bit-clock output runs only while a conversion is in progress, one pulse per bit period. A short-cycle selector can end the conversion after fewer than the full number of decided bits. The selector is captured when a conversion starts. The whole block runs from one system clock. Each bit period lasts a parameterised number of system clocks. The convert-start input is synchronised inside the block before its falling edge is detected.

Top module: `sc_sar_sequencer`

## Requirements
- R1: While reset is active and after it is released, with no conversion started, `busy_o` is 0, `bit_clk_o` is 0 and `code_n_o` is all ones.
- R2: A conversion starts only on the falling edge of `conv_start_i`. While the pulse is high, `busy_o` stays 0. Within 6 clocks after the pulse falls, `busy_o` goes to 1.
- R3: With N decided bits and a bit period of DIV clocks, `busy_o` stays high for exactly (N+1)*DIV+1 consecutive clocks.
- R4: During a conversion, `bit_clk_o` shows exactly N+1 rising edges, one per bit period, starting high in the first clock of each period. Whenever `busy_o` is 0, `bit_clk_o` is 0.
- R5: The comparator input `cmp_i` = 1 means the trial level (the bitwise complement of `code_n_o`) exceeds the analog input, so the bit under test is rejected. With an ideal DAC and comparator, the final `code_n_o` is the bitwise complement of the target's upper N bits. In this negative-true word, a 0 at a bit position means that bit is a 1 in the result.
- R6: `short_sel_i` chooses N as follows: 0 gives 16, 1 gives 15, 2 gives 14, 3 gives 13, 4 gives 12, 5 gives 10, 6 gives 8 and 7 gives 16. The WIDTH-N low-order bits, which are never decided, read 1 in the final word.
- R7: `short_sel_i` is sampled only when a conversion starts. Changing it during a conversion does not change the duration or the result.
- R8: A convert-start pulse that falls while `busy_o` is 1 is ignored. The running conversion keeps its duration and result, and no new conversion follows it.
- R9: `code_n_o` does not change on the clock where `busy_o` falls. It then holds its value while the block is idle, whatever `cmp_i` does.
- R10: On the clock where `busy_o` rises, `code_n_o` is all ones. It stays all ones until the first bit period ends.

Top module parameters: WIDTH (result bits, default 16), DIV (system clocks per bit period, default 4, at least 2), SYNC (depth of the start synchroniser, default 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_start_i | input | 1 | Convert-start pulse, active high; its falling edge starts a conversion |
| short_sel_i | input | 3 | Short-cycle length code, captured at start |
| cmp_i | input | 1 | Comparator: 1 = trial level above input (reject bit) |
| busy_o | output | 1 | Status: high while a conversion is in progress |
| bit_clk_o | output | 1 | Gated bit clock, low when idle |
| code_n_o | output | WIDTH | Negative-true trial/result word to the DAC and the data outputs |

## Verification
The bench goes after the decision at each end of the code range. An all-zero target makes every trial reject, and an all-one target makes every trial keep, so a design with an inverted comparator sense or a swapped negative-true bit gives the complemented word. Every short-cycle code is run, so a wrong code-to-length map, or a design that clears the first undecided bit, shows up as a wrong busy length, a wrong bit-clock count or a 0 in the undecided tail. Two further runs move the short-cycle selector during a conversion and fire a second convert pulse during one. A design that samples the selector late, or that restarts on the second pulse, stretches the busy time or starts a second conversion. After each run the comparator is forced to flip while the block is idle, so that a result register that keeps updating is caught.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Short-cycle code to number of decided bits, clamped to the word width.
  function automatic int unsigned sc_len(input logic [2:0] sel, input int unsigned width);
    int unsigned n;
    case (sel)
      3'd1:    n = 15;
      3'd2:    n = 14;
      3'd3:    n = 13;
      3'd4:    n = 12;
      3'd5:    n = 10;
      3'd6:    n = 8;
      default: n = 16;
    endcase
    if (n > width) n = width;
    return n;
  endfunction

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC:0] sh_q;
  logic [SYNC:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC-1:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  // High for one clock after the synchronised input goes from 1 to 0.
  assign fall_o = sh_q[SYNC] & ~sh_q[SYNC-1];
endmodule

// File: rtl/sar_bit_timer.sv
module sar_bit_timer #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o,
  output logic gclk_o
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;
  logic            phase_en;

  always_comb begin
    phase_en = 1'b1;
    if (!run_i)                phase_d = '0;
    else if (phase_q == PH_LAST) phase_d = '0;
    else                       phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign tick_o = run_i & (phase_q == PH_LAST);
  assign gclk_o = run_i & (phase_q < PH_HALF);
endmodule

// File: rtl/sar_bit_ctrl.sv
module sar_bit_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int STEP_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        sel_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              run_o,
  output logic              init_en_o,
  output logic              preset_en_o,
  output logic              dec_en_o,
  output logic              clr_en_o,
  output logic [STEP_W-1:0] step_o
);
  logic              busy_q, busy_d;
  logic              fin_q, fin_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [STEP_W-1:0] len_q, len_d;
  logic              start_ok;

  assign start_ok = start_i & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    fin_d  = fin_q;
    step_d = step_q;
    len_d  = len_q;
    if (start_ok) begin
      busy_d = 1'b1;
      fin_d  = 1'b0;
      step_d = '0;
      len_d  = STEP_W'(sc_len(sel_i, WIDTH));
    end else if (fin_q) begin
      busy_d = 1'b0;
      fin_d  = 1'b0;
    end else if (tick_i) begin
      if (step_q == len_q) fin_d  = 1'b1;
      else                 step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      step_q <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      step_q <= step_d;
      len_q  <= len_d;
    end
  end

  assign busy_o      = busy_q;
  assign run_o       = busy_q & ~fin_q;
  assign init_en_o   = start_ok;
  assign preset_en_o = tick_i & (step_q == '0);
  assign dec_en_o    = tick_i & (step_q != '0);
  assign clr_en_o    = tick_i & (step_q != '0) & (step_q < len_q);
  assign step_o      = step_q;
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH  = 16,
  parameter int STEP_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_en_i,
  input  logic              preset_en_i,
  input  logic              dec_en_i,
  input  logic              clr_en_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              cmp_i,
  output logic [WIDTH-1:0]  code_n_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // POS is the bit number counted from the MSB, starting at 1.
    localparam int POS = WIDTH - i;
    logic b_q, b_d, b_en;

    always_comb begin
      b_en = 1'b1;
      b_d  = b_q;
      if (init_en_i) begin
        b_d = 1'b1;
      end else if (preset_en_i) begin
        b_d = (POS == 1) ? 1'b0 : 1'b1;
      end else if (dec_en_i && step_i == STEP_W'(POS)) begin
        b_d = cmp_i;
      end else if (clr_en_i && step_i == STEP_W'(POS - 1)) begin
        b_d = 1'b0;
      end else begin
        b_en = 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   b_q <= 1'b1;
      else if (b_en) b_q <= b_d;
    end

    assign code_n_o[i] = b_q;
  end
endmodule

// File: rtl/sc_sar_sequencer.sv
module sc_sar_sequencer #(
  parameter int WIDTH = 16,
  parameter int DIV   = 4,
  parameter int SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_start_i,
  input  logic [2:0]       short_sel_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             bit_clk_o,
  output logic [WIDTH-1:0] code_n_o
);
  localparam int STEP_W = $clog2(WIDTH + 2);

  logic [1:0]        rs_q;
  logic              rst_n;
  logic              start_p;
  logic              tick;
  logic              run;
  logic              init_en, preset_en, dec_en, clr_en;
  logic [STEP_W-1:0] step;

  // The reset is asserted asynchronously and released in step with the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  sar_start_edge #(.SYNC(SYNC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .pin_i (conv_start_i),
    .fall_o(start_p)
  );

  sar_bit_timer #(.DIV(DIV)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .run_i (run),
    .tick_o(tick),
    .gclk_o(bit_clk_o)
  );

  sar_bit_ctrl #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_p),
    .sel_i      (short_sel_i),
    .tick_i     (tick),
    .busy_o     (busy_o),
    .run_o      (run),
    .init_en_o  (init_en),
    .preset_en_o(preset_en),
    .dec_en_o   (dec_en),
    .clr_en_o   (clr_en),
    .step_o     (step)
  );

  sar_trial_reg #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .init_en_i  (init_en),
    .preset_en_i(preset_en),
    .dec_en_i   (dec_en),
    .clr_en_i   (clr_en),
    .step_i     (step),
    .cmp_i      (cmp_i),
    .code_n_o   (code_n_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             gclk_i,
  input logic [WIDTH-1:0] code_n_i
);
  localparam int CNT_W = $clog2(WIDTH + 3);

  logic             gclk_prev_q;
  logic [CNT_W-1:0] rise_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gclk_prev_q <= 1'b0;
      rise_cnt_q  <= '0;
    end else begin
      gclk_prev_q <= gclk_i;
      if (!busy_i)                    rise_cnt_q <= '0;
      else if (gclk_i && !gclk_prev_q) rise_cnt_q <= rise_cnt_q + 1'b1;
    end
  end

  // R4
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !gclk_i);

  // R4
  bit_clk_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt_q <= CNT_W'(WIDTH + 1));

  // R9
  word_stable_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $stable(code_n_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i)) |-> $stable(code_n_i));

  // R10
  init_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (code_n_i == '1));
endmodule

bind sc_sar_sequencer sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy_o),
  .gclk_i  (bit_clk_o),
  .code_n_i(code_n_o)
);

// File: tb/sc_sar_sequencer_bench.sv
module sc_sar_sequencer_bench;
  localparam int W   = 16;
  localparam int DIV = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         conv;
  logic [2:0]   sel;
  logic         cmp;
  logic         busy;
  logic         gclk;
  logic [W-1:0] code_n;
  logic [W-1:0] target;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sc_sar_sequencer #(.WIDTH(W), .DIV(DIV), .SYNC(2)) u_sc_sar_sequencer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .conv_start_i(conv),
    .short_sel_i (sel),
    .cmp_i       (cmp),
    .busy_o      (busy),
    .bit_clk_o   (gclk),
    .code_n_o    (code_n)
  );

  // Ideal DAC and comparator: reject when the trial level exceeds the target.
  always_comb cmp = ((~code_n) > target);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bits_of(input logic [2:0] s);
    case (s)
      3'd1: return 15;
      3'd2: return 14;
      3'd3: return 13;
      3'd4: return 12;
      3'd5: return 10;
      3'd6: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [W-1:0] expect_n(input logic [W-1:0] t, input int n);
    logic [W-1:0] mask;
    mask = 16'hFFFF << (W - n);
    return ~(t & mask);
  endfunction

  task automatic test_reset();
    rst_n = 1'b0; conv = 1'b0; sel = 3'd0; target = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && gclk == 1'b0 && code_n == '1, "R1 in reset", {code_n, 14'd0, busy, gclk}, {16'hFFFF, 16'd0});
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(busy == 1'b0 && gclk == 1'b0 && code_n == '1, "R1 after release", {code_n, 14'd0, busy, gclk}, {16'hFFFF, 16'd0});
  endtask

  // mode 0: plain; 1: selector changed mid-run; 2: extra start pulse mid-run
  task automatic run_conv(input logic [2:0] s, input logic [W-1:0] t, input int mode);
    int n, cyc, rises, w;
    bit prev;
    logic [W-1:0] held;
    n = bits_of(s);
    target = t; sel = s;
    @(negedge clk);
    conv = 1'b1;
    repeat (8) @(negedge clk);
    check(busy == 1'b0, "R2 no start while pulse high", busy, 0);
    conv = 1'b0;
    w = 0;
    while (!busy && w < 6) begin @(negedge clk); w++; end
    check(busy == 1'b1, "R2 start after falling edge", busy, 1);
    check(code_n == '1, "R10 word all ones at start", code_n, 16'hFFFF);
    cyc = 0; rises = 0; prev = 1'b0;
    while (busy && cyc < 300) begin
      cyc++;
      if (gclk && !prev) rises++;
      prev = gclk;
      if (cyc == DIV - 1) check(code_n == '1, "R10 ones until first period ends", code_n, 16'hFFFF);
      if (mode == 1 && cyc == 6) sel = s ^ 3'd5;
      if (mode == 2 && cyc == 8) conv = 1'b1;
      if (mode == 2 && cyc == 12) conv = 1'b0;
      @(negedge clk);
    end
    check(cyc == (n + 1) * DIV + 1, mode == 1 ? "R7 duration with selector moved" : (mode == 2 ? "R8 duration with extra pulse" : "R3 busy length"), cyc, (n + 1) * DIV + 1);
    check(rises == n + 1, "R4 bit clock edges", rises, n + 1);
    check(code_n == expect_n(t, n), n < W ? "R6 short-cycle result" : (mode == 1 ? "R7 result" : "R5 full result"), code_n, expect_n(t, n));
    held = code_n;
    target = ~t;
    repeat (10) @(negedge clk);
    check(code_n == held, "R9 word held while idle", code_n, held);
    check(busy == 1'b0 && gclk == 1'b0, mode == 2 ? "R8 no restart" : "R4 idle clock low", {busy, gclk}, 0);
    sel = 3'd0;
  endtask

  task automatic test_ends();
    run_conv(3'd0, 16'h0000, 0);
    run_conv(3'd0, 16'hFFFF, 0);
    run_conv(3'd0, 16'h8000, 0);
    run_conv(3'd0, 16'h7FFF, 0);
  endtask

  task automatic test_short_all();
    for (int s = 0; s < 8; s++) begin
      run_conv(3'(s), 16'($urandom), 0);
      run_conv(3'(s), 16'hFFFF, 0);
    end
  endtask

  task automatic test_disturb();
    run_conv(3'd6, 16'hA5C3, 1);
    run_conv(3'd2, 16'h3C5A, 2);
    run_conv(3'd0, 16'h1234, 2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    test_reset();
    test_ends();
    test_short_all();
    test_disturb();
    for (int k = 0; k < 6; k++) run_conv(3'd0, 16'($urandom), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end
endmodule